// File: doc/BRIEF.md
# ACPI Power-Rail Sequencing Controller

This block is the digital sequencer of a multi-rail power controller that supplies a memory core rail, a two-stage chipset core LDO and a termination rail. Two power-on-reset flags qualify the standby bias and the 12V bias. The active-low sleep inputs are synchronized and decoded into a run state (S0), a suspend state (S3) or an off state (S5).

A cold start begins when both sleep inputs read high and both bias flags are present. The block then holds the PWM error-amplifier reset for three soft-start periods. Next, the memory core rail and the upper core LDO are enabled, and both ramp their digital reference codes from zero to full scale over one period. The termination rail is enabled one period later, and the lower core LDO one period after that. Analog regulation, comparators and drivers are outside this block and report to it through flag inputs. The block drives the rail enables, the reference ramp codes and a power-good output. An undervoltage flag seen after soft-start latches a fault that turns every rail off.

One soft-start period lasts 2^SS_W clocks. SS_W is set so that this is about 8.2 ms at the system clock, which makes the amplifier reset about 24 ms.

Top module: `acpi_seq_ctrl`

## Requirements
- R1: After reset every output is 0: enables, amplifier reset, both ramp codes and power-good.
- R2: The block stays off until the synchronized sleep inputs are both high and both bias flags are high. A change on a sleep input takes effect on the third rising clock edge after it, because of the two-flop synchronizer. The bias flags are not synchronized.
- R3: On a cold start, amp_rst_o is high for exactly 3·2^SS_W clocks, and every rail enable is low during that time.
- R4: When the reset interval ends, mem_en_o and ldo_up_en_o rise together. For one period both ramp codes equal the clock index within the period (0 to 2^SS_W−1) shifted right by SS_W−RAMP_W, so the last step is all ones.
- R5: tt_en_o rises one period after the ramp begins and the ramp codes then hold all ones. ldo_lo_en_o rises one period after tt_en_o.
- R6: pgood_o is high only when the full sequence has completed, the block is in the run state and ldo_inreg_i is high. It is low during soft-start, in suspend, when off and after a fault.
- R7: Undervoltage flags have no effect during the amplifier reset, the ramp period or the termination period.
- R8: In the run state, any high undervoltage flag turns every output off at the next edge. This fault stays latched until the synchronized SLP_S5# reads low or a bias flag drops.
- R9: A suspend decode (SLP_S5# high, SLP_S3# low) in the run state keeps only mem_en_o, with the memory ramp at all ones. On wake, the upper LDO re-ramps from 0 while the memory ramp stays at all ones, and the sequence then continues as in R5.
- R10: If either synchronized sleep input goes low during the reset, ramp or termination period, the block aborts to off.
- R11: If either bias flag is low, every output is 0 after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sby_por_i | input | 1 | Standby bias above its POR threshold |
| p12_por_i | input | 1 | 12V bias above its POR threshold |
| slp_s3_ni | input | 1 | Suspend request, active low, asynchronous |
| slp_s5_ni | input | 1 | Off request, active low, asynchronous |
| ldo_inreg_i | input | 1 | Core LDO within regulation |
| uv_mem_i | input | 1 | Memory rail feedback undervoltage |
| uv_ldo_i | input | 1 | Core LDO feedback undervoltage |
| uv_tt_i | input | 1 | Termination rail feedback undervoltage |
| amp_rst_o | output | 1 | PWM error-amplifier reset |
| mem_en_o | output | 1 | Memory core rail enable |
| ldo_up_en_o | output | 1 | Upper core LDO enable |
| tt_en_o | output | 1 | Termination rail enable |
| ldo_lo_en_o | output | 1 | Lower core LDO enable |
| mem_ramp_o | output | RAMP_W | Memory rail reference code |
| ldo_ramp_o | output | RAMP_W | Upper core LDO reference code |
| pgood_o | output | 1 | Core power good |

## Verification
The bench checks every clock of the ramp and the exact first and last clocks of the three-period amplifier reset. A timer that is off by one, or a reset that counts the wrong number of periods, would shift these edges, and these checks would catch it. Undervoltage flags are held high across the soft-start window to confirm that they are ignored there; a monitor that runs too early would kill the rails in the middle of the sequence. Once a fault has latched, the flags are cleared, and the bench confirms that the rails stay off until SLP_S5# or a bias flag drops. The suspend and wake path checks that the memory rail is not re-ramped. A design that reused the cold path would pull its reference down to zero.

// File: rtl/acpi_seq_pkg.sv
package acpi_seq_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_AMPRST,
    ST_RAMP,
    ST_TT,
    ST_RUN,
    ST_SUSP,
    ST_FAULT
  } seq_state_e;
endpackage

// File: rtl/acpi_sync.sv
module acpi_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/acpi_ss_timer.sv
module acpi_ss_timer #(
  parameter int SS_W   = 13,
  parameter int RAMP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  output logic              tick_o,
  output logic [RAMP_W-1:0] step_o
);
  logic [SS_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (run_i) cnt_q <= cnt_q + 1'b1;
    else            cnt_q <= '0;
  end

  // last clock of a soft-start period
  assign tick_o = run_i & (&cnt_q);
  assign step_o = cnt_q[SS_W-1 -: RAMP_W];
endmodule

// File: rtl/acpi_rail_out.sv
module acpi_rail_out
  import acpi_seq_pkg::*;
#(
  parameter int RAMP_W = 8
) (
  input  seq_state_e        state_i,
  input  logic              warm_i,
  input  logic [RAMP_W-1:0] step_i,
  input  logic              inreg_i,
  output logic              amp_rst_o,
  output logic              mem_en_o,
  output logic              ldo_up_en_o,
  output logic              tt_en_o,
  output logic              ldo_lo_en_o,
  output logic [RAMP_W-1:0] mem_ramp_o,
  output logic [RAMP_W-1:0] ldo_ramp_o,
  output logic              pgood_o
);
  localparam logic [RAMP_W-1:0] FULL = '1;

  always_comb begin
    amp_rst_o   = (state_i == ST_AMPRST);
    ldo_up_en_o = (state_i inside {ST_RAMP, ST_TT, ST_RUN});
    mem_en_o    = ldo_up_en_o | (state_i == ST_SUSP);
    tt_en_o     = (state_i inside {ST_TT, ST_RUN});
    ldo_lo_en_o = (state_i == ST_RUN);
    pgood_o     = ldo_lo_en_o & inreg_i;
    ldo_ramp_o  = '0;
    mem_ramp_o  = '0;
    if (state_i == ST_RAMP) begin
      ldo_ramp_o = step_i;
      mem_ramp_o = warm_i ? FULL : step_i;
    end else if (tt_en_o) begin
      ldo_ramp_o = FULL;
      mem_ramp_o = FULL;
    end else if (state_i == ST_SUSP) begin
      mem_ramp_o = FULL;
    end
  end
endmodule

// File: rtl/acpi_seq_ctrl.sv
module acpi_seq_ctrl
  import acpi_seq_pkg::*;
#(
  parameter int SS_W       = 13,
  parameter int RAMP_W     = 8,
  parameter int AMP_CYCLES = 3,
  parameter int SYNC_STG   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sby_por_i,
  input  logic              p12_por_i,
  input  logic              slp_s3_ni,
  input  logic              slp_s5_ni,
  input  logic              ldo_inreg_i,
  input  logic              uv_mem_i,
  input  logic              uv_ldo_i,
  input  logic              uv_tt_i,
  output logic              amp_rst_o,
  output logic              mem_en_o,
  output logic              ldo_up_en_o,
  output logic              tt_en_o,
  output logic              ldo_lo_en_o,
  output logic [RAMP_W-1:0] mem_ramp_o,
  output logic [RAMP_W-1:0] ldo_ramp_o,
  output logic              pgood_o
);
  localparam int CYC_W = $clog2(AMP_CYCLES + 1);
  localparam logic [CYC_W-1:0] CYC_LAST = CYC_W'(AMP_CYCLES - 1);

  seq_state_e        state_q, state_d;
  logic [1:0]        slp_q;
  logic              s3_hi, s5_hi, por_ok, uv_any;
  logic              ss_tick, warm_q;
  logic [RAMP_W-1:0] ss_step;
  logic [CYC_W-1:0]  cyc_q;

  acpi_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({slp_s5_ni, slp_s3_ni}),
    .q_o   (slp_q)
  );

  assign s3_hi  = slp_q[0];
  assign s5_hi  = slp_q[1];
  assign por_ok = sby_por_i & p12_por_i;
  assign uv_any = uv_mem_i | uv_ldo_i | uv_tt_i;

  acpi_ss_timer #(.SS_W(SS_W), .RAMP_W(RAMP_W)) u_tmr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .run_i (state_q inside {ST_AMPRST, ST_RAMP, ST_TT}),
    .tick_o(ss_tick),
    .step_o(ss_step)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_OFF:    if (s3_hi && s5_hi) state_d = ST_AMPRST;
      ST_AMPRST: if (!(s3_hi && s5_hi)) state_d = ST_OFF;
                 else if (ss_tick && cyc_q == CYC_LAST) state_d = ST_RAMP;
      ST_RAMP:   if (!(s3_hi && s5_hi)) state_d = ST_OFF;
                 else if (ss_tick) state_d = ST_TT;
      ST_TT:     if (!(s3_hi && s5_hi)) state_d = ST_OFF;
                 else if (ss_tick) state_d = ST_RUN;
      ST_RUN:    if (!s5_hi) state_d = ST_OFF;
                 else if (!s3_hi) state_d = ST_SUSP;
                 else if (uv_any) state_d = ST_FAULT;
      ST_SUSP:   if (!s5_hi) state_d = ST_OFF;
                 else if (s3_hi) state_d = ST_RAMP;
      ST_FAULT:  if (!s5_hi) state_d = ST_OFF;
      default:   state_d = ST_OFF;
    endcase
    if (!por_ok) state_d = ST_OFF;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_OFF;
      cyc_q   <= '0;
      warm_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q != ST_AMPRST) cyc_q <= '0;
      else if (ss_tick)         cyc_q <= cyc_q + 1'b1;
      // memory rail already up when waking from suspend
      if (state_q == ST_SUSP)     warm_q <= 1'b1;
      else if (state_q == ST_OFF) warm_q <= 1'b0;
    end
  end

  acpi_rail_out #(.RAMP_W(RAMP_W)) u_out (
    .state_i    (state_q),
    .warm_i     (warm_q),
    .step_i     (ss_step),
    .inreg_i    (ldo_inreg_i),
    .amp_rst_o  (amp_rst_o),
    .mem_en_o   (mem_en_o),
    .ldo_up_en_o(ldo_up_en_o),
    .tt_en_o    (tt_en_o),
    .ldo_lo_en_o(ldo_lo_en_o),
    .mem_ramp_o (mem_ramp_o),
    .ldo_ramp_o (ldo_ramp_o),
    .pgood_o    (pgood_o)
  );
endmodule

// File: rtl/acpi_seq_chk.sv
module acpi_seq_chk #(
  parameter int RAMP_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sby_por_i,
  input logic              p12_por_i,
  input logic              ldo_inreg_i,
  input logic              amp_rst_o,
  input logic              mem_en_o,
  input logic              ldo_up_en_o,
  input logic              tt_en_o,
  input logic              ldo_lo_en_o,
  input logic [RAMP_W-1:0] mem_ramp_o,
  input logic [RAMP_W-1:0] ldo_ramp_o,
  input logic              pgood_o
);
  // R3
  amp_rails_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    amp_rst_o |-> !(mem_en_o || ldo_up_en_o || tt_en_o || ldo_lo_en_o));

  // R4
  ramp_from_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mem_en_o) |-> (mem_ramp_o == '0) && (ldo_ramp_o == '0));

  // R5
  lo_after_tt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ldo_lo_en_o) |-> tt_en_o && $past(tt_en_o));

  // R6
  pgood_qual_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pgood_o |-> ldo_inreg_i && ldo_lo_en_o);

  // R9
  susp_mem_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_en_o && !ldo_up_en_o) |-> (mem_ramp_o == '1) && (ldo_ramp_o == '0));

  // R11
  por_loss_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sby_por_i || !p12_por_i) |=>
      !(amp_rst_o || mem_en_o || ldo_up_en_o || tt_en_o || ldo_lo_en_o || pgood_o)
      && (mem_ramp_o == '0) && (ldo_ramp_o == '0));
endmodule

bind acpi_seq_ctrl acpi_seq_chk #(.RAMP_W(RAMP_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .sby_por_i  (sby_por_i),
  .p12_por_i  (p12_por_i),
  .ldo_inreg_i(ldo_inreg_i),
  .amp_rst_o  (amp_rst_o),
  .mem_en_o   (mem_en_o),
  .ldo_up_en_o(ldo_up_en_o),
  .tt_en_o    (tt_en_o),
  .ldo_lo_en_o(ldo_lo_en_o),
  .mem_ramp_o (mem_ramp_o),
  .ldo_ramp_o (ldo_ramp_o),
  .pgood_o    (pgood_o)
);

// File: tb/sim_acpi_seq_ctrl.sv
module sim_acpi_seq_ctrl;
  localparam int SSW = 6;
  localparam int RW  = 4;
  localparam int OW  = 6 + 2 * RW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sby = 1'b0, p12 = 1'b0, s3n = 1'b0, s5n = 1'b0, inreg = 1'b0;
  logic uvm = 1'b0, uvl = 1'b0, uvt = 1'b0;
  logic amp, mem, lup, tt, llo, pg;
  logic [RW-1:0] mr, lr;

  always #2 clk = ~clk;

  acpi_seq_ctrl #(.SS_W(SSW), .RAMP_W(RW)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sby_por_i(sby), .p12_por_i(p12),
    .slp_s3_ni(s3n), .slp_s5_ni(s5n), .ldo_inreg_i(inreg),
    .uv_mem_i(uvm), .uv_ldo_i(uvl), .uv_tt_i(uvt),
    .amp_rst_o(amp), .mem_en_o(mem), .ldo_up_en_o(lup), .tt_en_o(tt),
    .ldo_lo_en_o(llo), .mem_ramp_o(mr), .ldo_ramp_o(lr), .pgood_o(pg)
  );

  wire [OW-1:0] obs = {amp, mem, lup, tt, llo, pg, mr, lr};

  typedef struct {
    string         tag;
    logic [OW-1:0] exp;
  } item_t;

  item_t q[$];
  int total = 0, bad = 0;
  int i = 0;

  function automatic logic [OW-1:0] mk(bit a, bit m, bit u, bit t, bit l, bit p,
                                       int mrv, int lrv);
    return {a, m, u, t, l, p, RW'(mrv), RW'(lrv)};
  endfunction

  localparam logic [OW-1:0] ZERO = '0;

  task automatic expect_now(string tag, logic [OW-1:0] e);
    q.push_back('{tag, e});
  endtask

  task automatic step(int n);
    repeat (n) begin
      @(negedge clk);
      i++;
    end
  endtask

  task automatic go(int k);
    while (i < k) step(1);
  endtask

  task automatic wait_run(string tag);
    int n;
    n = 0;
    while (!llo && n < 1000) begin
      step(1);
      n++;
    end
    if (!llo) begin
      total++;
      bad++;
      $display("FAIL %s run state not reached actual=0 expected=1", tag);
    end
  endtask

  // monitor
  initial forever begin
    item_t it;
    @(negedge clk);
    #1;
    while (q.size() > 0) begin
      it = q.pop_front();
      total++;
      if (obs !== it.exp) begin
        bad++;
        $display("FAIL %s actual=%h expected=%h", it.tag, obs, it.exp);
      end
    end
  end

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    step(3);
    expect_now("R1 reset state", ZERO);
    step(1);
    rst_ni = 1'b1;
    inreg  = 1'b1;

    // R2 qualification
    sby = 1; p12 = 1; s5n = 0; s3n = 1;
    step(8); expect_now("R2 s5 low stays off", ZERO);
    s5n = 1; p12 = 0;
    step(8); expect_now("R2 12V missing stays off", ZERO);
    s3n = 0;
    step(8);
    p12 = 1;
    step(8); expect_now("R2 s3 low stays off", ZERO);
    s3n = 1;
    step(1); expect_now("R2 sync edge1", ZERO);
    step(1); expect_now("R2 sync edge2", ZERO);
    step(1); expect_now("R2 start on edge3", mk(1,0,0,0,0,0,0,0));

    // R3 / R7 / R4 / R5 cold sequence, index from AMPRST entry
    i = 0;
    go(1);   expect_now("R3 amp first", mk(1,0,0,0,0,0,0,0));
    go(100); uvm = 1; uvt = 1;
    go(191); expect_now("R3 amp last clock R7", mk(1,0,0,0,0,0,0,0));
    for (int j = 0; j < 64; j++) begin
      go(192 + j);
      if (j == 58) begin uvm = 0; uvt = 0; uvl = 1; end
      expect_now("R4 ramp step R7", mk(0,1,1,0,0,0,j >> 2,j >> 2));
    end
    go(256); expect_now("R5 tt enable", mk(0,1,1,1,0,0,15,15));
    go(300); uvl = 0; uvm = 1;
    go(318); uvm = 0;
    go(319); expect_now("R5 tt last clock", mk(0,1,1,1,0,0,15,15));
    go(320); expect_now("R5 lower ldo R6 pgood", mk(0,1,1,1,1,1,15,15));
    go(322); inreg = 0;
    expect_now("R6 pgood needs inreg", mk(0,1,1,1,1,0,15,15));
    step(1); inreg = 1;

    // R8 fault latch
    uvl = 1;
    step(1); expect_now("R8 fault kills rails", ZERO);
    uvl = 0;
    step(10); expect_now("R8 fault latched", ZERO);
    s5n = 0;
    step(4); expect_now("R8 off pass", ZERO);
    s5n = 1;
    step(3); expect_now("R8 cleared via off", mk(1,0,0,0,0,0,0,0));

    // R10 abort
    s3n = 0;
    step(2); expect_now("R10 before sync", mk(1,0,0,0,0,0,0,0));
    step(1); expect_now("R10 abort", ZERO);
    s3n = 1;
    step(3); expect_now("R10 restart", mk(1,0,0,0,0,0,0,0));

    // R11 standby loss
    sby = 0;
    step(1); expect_now("R11 standby loss", ZERO);
    sby = 1;
    step(1);
    wait_run("R9 pre");
    expect_now("R9 in run", mk(0,1,1,1,1,1,15,15));

    // R9 suspend and wake
    s3n = 0;
    step(3); expect_now("R9 suspend", mk(0,1,0,0,0,0,15,0));
    s3n = 1;
    step(2); expect_now("R9 still suspend", mk(0,1,0,0,0,0,15,0));
    step(1); expect_now("R9 wake ramp", mk(0,1,1,0,0,0,15,0));
    step(4); expect_now("R9 warm ramp step", mk(0,1,1,0,0,0,15,1));
    step(60); expect_now("R9 warm tt", mk(0,1,1,1,0,0,15,15));
    wait_run("R9 resume");
    expect_now("R9 resumed run", mk(0,1,1,1,1,1,15,15));

    // R11 12V loss
    p12 = 0;
    step(1); expect_now("R11 12V loss", ZERO);
    p12 = 1;
    step(1);
    wait_run("R8 second");

    // R8 fault cleared by standby loss
    uvm = 1;
    step(1); expect_now("R8 fault again", ZERO);
    uvm = 0; sby = 0;
    step(1);
    sby = 1;
    step(1); expect_now("R8 cleared by standby", mk(1,0,0,0,0,0,0,0));

    step(2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule